// File: doc/BRIEF.md
# Master Clock Ratio and Speed Detector

This block measures how many master-clock cycles fit in one period of the frame clock. The frame clock is brought into the master-clock domain by a synchroniser, and the cycles between two of its rising edges are counted. The count is compared with eight nominal ratios: 128, 192, 256, 384, 512, 768, 1024 and 1536. A count matches a ratio when it lies within a small window around it. The two clocks must run at a fixed frequency relationship, but the phase between them can be anything.

A two-bit speed select decides how a matched ratio is used. It either fixes the speed class and limits which ratios are accepted, or it lets the measured ratio choose the class. The result is a speed mode and a two-bit oversampling code, which the interpolation filter downstream uses. A change is taken only after two frames in a row agree. A ratio that is not accepted raises an error and leaves the current mode where it was.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While `rst_n` is low, and after it is released, `spd_mode` is 00, `osr_code` is 0, and `mode_valid`, `ratio_err` and `locked` are all 0.
- R2: With `spd_sel` = 00 (normal), periods of 256, 384, 512 and 768 cycles give `spd_mode` = 00 and `osr_code` 0, 1, 2 and 3 respectively.
- R3: With `spd_sel` = 01 (double), periods of 128, 192, 256 and 384 cycles give `spd_mode` = 01 and `osr_code` 0, 1, 2 and 3.
- R4: With `spd_sel` = 10 (half), periods of 512, 768, 1024 and 1536 cycles give `spd_mode` = 10 and `osr_code` 0, 1, 2 and 3.
- R5: With `spd_sel` = 11 (automatic), the speed mode comes from the period alone. 128, 192, 256 and 384 give double speed with codes 0 to 3. 512 and 768 give normal speed with codes 2 and 3. 1024 and 1536 give half speed with codes 2 and 3.
- R6: A period matches a nominal ratio when it is within TOL cycles of it (TOL = 2 by default). A period TOL+1 cycles away from every nominal ratio matches nothing.
- R7: A measured period that matches no ratio, or matches a ratio the selected mode does not accept, sets `ratio_err` and clears `locked`. `spd_mode` and `osr_code` keep their previous values.
- R8: `spd_mode` and `osr_code` change only after two consecutive measurements give the same legal classification. A single frame with a different legal ratio leaves them unchanged and clears `locked`. `locked` is 1 when the latest measurement is legal and equal to the current output.
- R9: `mode_valid` rises with the first accepted classification and then stays high until reset. If only illegal periods have been seen, it stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_clk | input | 1 | Frame-rate clock, asynchronous to the logic and synchronised inside |
| spd_sel | input | 2 | Speed select: 00 normal, 01 double, 10 half, 11 automatic |
| spd_mode | output | 2 | Resolved speed: 00 normal, 01 double, 10 half |
| osr_code | output | 2 | Position of the measured ratio in the ascending list of four ratios for the resolved mode |
| mode_valid | output | 1 | At least one classification has been accepted since reset |
| ratio_err | output | 1 | The latest measurement was illegal for the selected mode |
| locked | output | 1 | The latest measurement is legal and agrees with the outputs |

## Verification
The assertions assume that the master clock keeps running. They also assume that each frame period is a whole number of master-clock cycles, and that the speed select changes only together with a frame rising edge. The stimulus builds every frame out of exactly the stated number of cycles, driven on the falling clock edge, so the first measurement after a change of rate already carries the new period. The speed select is changed only at the start of a frame. Outputs are sampled at the end of the fifth frame of each setting, well after the two agreeing measurements the hold rule needs.

// File: rtl/mclk_ratio_pkg.sv
package mclk_ratio_pkg;

   typedef enum logic [1:0] {
      SPD_NORMAL = 2'b00,
      SPD_DOUBLE = 2'b01,
      SPD_HALF   = 2'b10,
      SPD_AUTO   = 2'b11
   } spd_e;

   localparam int NUM_RATIOS = 8;
   localparam int IDX_W      = $clog2(NUM_RATIOS);

   typedef struct packed {
      logic [1:0] mode;
      logic [1:0] osr;
   } cand_t;

   // Ratios alternate x1 and x1.5, and double every two entries.
   function automatic int nominal_ratio(input int base, input int idx);
      int r;
      r = (idx % 2 == 1) ? (base * 3) / 2 : base;
      return r << (idx / 2);
   endfunction

endpackage

// File: rtl/frame_edge_sync.sv
module frame_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_in,
   output logic frame_rise
);
   logic synced;
   logic last_q;

   generate
      if (STAGES == 0) begin : g_bypass
         assign synced = frame_in;
      end else begin : g_sync
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= (sh_q << 1) | STAGES'(frame_in);
         end
         assign synced = sh_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= synced;
   end

   assign frame_rise = synced & ~last_q;
endmodule

// File: rtl/period_counter.sv
module period_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_rise,
   output logic [CNT_W-1:0] meas,
   output logic             meas_vld
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             armed_q;

   // saturate so a stopped frame clock never wraps into a legal count
   assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         armed_q  <= 1'b0;
         meas     <= '0;
         meas_vld <= 1'b0;
      end else begin
         meas_vld <= 1'b0;
         if (frame_rise) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
            if (armed_q) begin
               meas     <= cnt_inc;
               meas_vld <= 1'b1;
            end
         end else begin
            cnt_q <= cnt_inc;
         end
      end
   end
endmodule

// File: rtl/ratio_classifier.sv
module ratio_classifier
   import mclk_ratio_pkg::*;
#(
   parameter int BASE_RATIO = 128,
   parameter int TOL        = 2,
   parameter int CNT_W      = 12
) (
   input  logic [CNT_W-1:0] meas,
   output logic             match,
   output logic [IDX_W-1:0] idx
);
   logic [NUM_RATIOS-1:0] hit;

   generate
      for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
         localparam int NOM = nominal_ratio(BASE_RATIO, i);
         localparam logic [CNT_W-1:0] LO = CNT_W'(NOM - TOL);
         localparam logic [CNT_W-1:0] HI = CNT_W'(NOM + TOL);
         assign hit[i] = (meas >= LO) && (meas <= HI);
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int k = 0; k < NUM_RATIOS; k++) begin
         if (hit[k]) idx = IDX_W'(k);
      end
   end

   assign match = |hit;
endmodule

// File: rtl/mode_resolver.sv
module mode_resolver
   import mclk_ratio_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             meas_vld,
   input  logic             match,
   input  logic [IDX_W-1:0] idx,
   input  logic [1:0]       spd_sel,
   output logic [1:0]       spd_mode,
   output logic [1:0]       osr_code,
   output logic             mode_valid,
   output logic             ratio_err,
   output logic             locked
);
   cand_t cand, prev_q, cur_q;
   logic  legal, prev_ok_q;
   logic  lo_half, hi_half;

   assign lo_half = (idx <= 3'd3);
   assign hi_half = (idx >= 3'd4);

   always_comb begin
      cand  = '{mode: SPD_NORMAL, osr: idx[1:0] - 2'd2};
      legal = 1'b0;
      case (spd_e'(spd_sel))
         SPD_NORMAL: begin
            legal = match && (idx >= 3'd2) && (idx <= 3'd5);
         end
         SPD_DOUBLE: begin
            legal = match && lo_half;
            cand  = '{mode: SPD_DOUBLE, osr: idx[1:0]};
         end
         SPD_HALF: begin
            legal = match && hi_half;
            cand  = '{mode: SPD_HALF, osr: idx[1:0]};
         end
         default: begin
            legal = match;
            if (lo_half)          cand = '{mode: SPD_DOUBLE, osr: idx[1:0]};
            else if (idx >= 3'd6) cand = '{mode: SPD_HALF, osr: idx[1:0]};
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q     <= '0;
         prev_ok_q  <= 1'b0;
         cur_q      <= '{mode: SPD_NORMAL, osr: 2'd0};
         mode_valid <= 1'b0;
         ratio_err  <= 1'b0;
         locked     <= 1'b0;
      end else if (meas_vld) begin
         prev_q    <= cand;
         prev_ok_q <= legal;
         ratio_err <= !legal;
         if (legal && prev_ok_q && (cand == prev_q)) begin
            cur_q      <= cand;
            mode_valid <= 1'b1;
            locked     <= 1'b1;
         end else begin
            locked <= legal && (cand == cur_q);
         end
      end
   end

   assign spd_mode = cur_q.mode;
   assign osr_code = cur_q.osr;

   // R7
   illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_vld && !legal) |=> ($stable(cur_q) && ratio_err && !locked));

   // R8
   single_frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_vld && !(prev_ok_q && cand == prev_q)) |=> $stable(cur_q));

   // R8
   quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_vld |=> ($stable(cur_q) && $stable(locked) && $stable(ratio_err)));

   // R9
   valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_valid |=> mode_valid);

   // R5
   mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spd_mode != SPD_AUTO);

   // R7
   lock_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> !ratio_err);
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
   import mclk_ratio_pkg::*;
#(
   parameter int BASE_RATIO  = 128,
   parameter int TOL         = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_mclk,
   input  logic       rst_n,
   input  logic       frame_clk,
   input  logic [1:0] spd_sel,
   output logic [1:0] spd_mode,
   output logic [1:0] osr_code,
   output logic       mode_valid,
   output logic       ratio_err,
   output logic       locked
);
   localparam int MAX_RATIO = nominal_ratio(BASE_RATIO, NUM_RATIOS - 1);
   localparam int CNT_W     = $clog2(MAX_RATIO + TOL + 1) + 1;

   generate
      if (BASE_RATIO < 16 || BASE_RATIO % 2 != 0) begin : g_bad_base
         $error("BASE_RATIO must be even and at least 16");
      end
      if (TOL < 0 || TOL >= BASE_RATIO / 8) begin : g_bad_tol
         $error("TOL must leave the match windows disjoint");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES out of range");
      end
   endgenerate

   logic             frame_rise;
   logic [CNT_W-1:0] meas;
   logic             meas_vld;
   logic             match;
   logic [IDX_W-1:0] idx;

   frame_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk_mclk), .rst_n(rst_n), .frame_in(frame_clk), .frame_rise(frame_rise)
   );

   period_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk_mclk), .rst_n(rst_n), .frame_rise(frame_rise),
      .meas(meas), .meas_vld(meas_vld)
   );

   ratio_classifier #(.BASE_RATIO(BASE_RATIO), .TOL(TOL), .CNT_W(CNT_W)) u_cls (
      .meas(meas), .match(match), .idx(idx)
   );

   mode_resolver u_res (
      .clk(clk_mclk), .rst_n(rst_n), .meas_vld(meas_vld), .match(match), .idx(idx),
      .spd_sel(spd_sel), .spd_mode(spd_mode), .osr_code(osr_code),
      .mode_valid(mode_valid), .ratio_err(ratio_err), .locked(locked)
   );
endmodule

// File: tb/mclk_ratio_detect_tb.sv
module mclk_ratio_detect_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_clk = 1'b0;
   logic [1:0] spd_sel = 2'b00;
   logic [1:0] spd_mode, osr_code;
   logic       mode_valid, ratio_err, locked;
   int         n_checks = 0;
   int         n_errors = 0;

   always #10 clk = ~clk;

   mclk_ratio_detect u_dut (
      .clk_mclk(clk), .rst_n(rst_n), .frame_clk(frame_clk), .spd_sel(spd_sel),
      .spd_mode(spd_mode), .osr_code(osr_code), .mode_valid(mode_valid),
      .ratio_err(ratio_err), .locked(locked)
   );

   typedef struct packed {
      logic [1:0]  sel;
      logic [11:0] per;
      logic [1:0]  mode;
      logic [1:0]  osr;
      logic        err;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 27;
   // R2 rows 0-3, R7 error rows keep the prior mode, R3, R4, R5, then R6 windows
   localparam vec_t VEC [NV] = '{
      '{2'd0, 12'd256,  2'd0, 2'd0, 1'b0, 8'd2},
      '{2'd0, 12'd384,  2'd0, 2'd1, 1'b0, 8'd2},
      '{2'd0, 12'd512,  2'd0, 2'd2, 1'b0, 8'd2},
      '{2'd0, 12'd768,  2'd0, 2'd3, 1'b0, 8'd2},
      '{2'd0, 12'd1024, 2'd0, 2'd3, 1'b1, 8'd7},
      '{2'd1, 12'd128,  2'd1, 2'd0, 1'b0, 8'd3},
      '{2'd1, 12'd192,  2'd1, 2'd1, 1'b0, 8'd3},
      '{2'd1, 12'd256,  2'd1, 2'd2, 1'b0, 8'd3},
      '{2'd1, 12'd384,  2'd1, 2'd3, 1'b0, 8'd3},
      '{2'd1, 12'd512,  2'd1, 2'd3, 1'b1, 8'd7},
      '{2'd2, 12'd512,  2'd2, 2'd0, 1'b0, 8'd4},
      '{2'd2, 12'd768,  2'd2, 2'd1, 1'b0, 8'd4},
      '{2'd2, 12'd1024, 2'd2, 2'd2, 1'b0, 8'd4},
      '{2'd2, 12'd1536, 2'd2, 2'd3, 1'b0, 8'd4},
      '{2'd2, 12'd384,  2'd2, 2'd3, 1'b1, 8'd7},
      '{2'd3, 12'd128,  2'd1, 2'd0, 1'b0, 8'd5},
      '{2'd3, 12'd384,  2'd1, 2'd3, 1'b0, 8'd5},
      '{2'd3, 12'd512,  2'd0, 2'd2, 1'b0, 8'd5},
      '{2'd3, 12'd768,  2'd0, 2'd3, 1'b0, 8'd5},
      '{2'd3, 12'd1024, 2'd2, 2'd2, 1'b0, 8'd5},
      '{2'd3, 12'd1536, 2'd2, 2'd3, 1'b0, 8'd5},
      '{2'd3, 12'd1000, 2'd2, 2'd3, 1'b1, 8'd7},
      '{2'd0, 12'd258,  2'd0, 2'd0, 1'b0, 8'd6},
      '{2'd0, 12'd254,  2'd0, 2'd0, 1'b0, 8'd6},
      '{2'd0, 12'd259,  2'd0, 2'd0, 1'b1, 8'd6},
      '{2'd1, 12'd190,  2'd1, 2'd1, 1'b0, 8'd6},
      '{2'd1, 12'd189,  2'd1, 2'd1, 1'b1, 8'd6}
   };

   task automatic chk(input int got, input int exp, input string req, input string what);
      n_checks++;
      if (got != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
      end
   endtask

   task automatic run_frames(input int per, input int n);
      for (int f = 0; f < n; f++) begin
         frame_clk = 1'b1;
         repeat (per / 2) @(negedge clk);
         frame_clk = 1'b0;
         repeat (per - per / 2) @(negedge clk);
      end
   endtask

   task automatic check_reset_state();
      chk(int'(spd_mode), 0, "R1", "spd_mode");
      chk(int'(osr_code), 0, "R1", "osr_code");
      chk(int'(mode_valid), 0, "R1", "mode_valid");
      chk(int'(ratio_err), 0, "R1", "ratio_err");
      chk(int'(locked), 0, "R1", "locked");
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      string tag;
      // R1: state held in and just after reset
      repeat (3) @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_reset_state();

      // R9: only illegal periods seen, nothing accepted yet
      spd_sel = 2'b00;
      run_frames(1024, 5);
      chk(int'(mode_valid), 0, "R9", "mode_valid after illegal only");
      chk(int'(ratio_err), 1, "R9", "ratio_err after illegal only");
      chk(int'(spd_mode), 0, "R9", "spd_mode untouched");
      chk(int'(osr_code), 0, "R9", "osr_code untouched");

      // table walk: R2 R3 R4 R5 R6 R7
      for (int v = 0; v < NV; v++) begin
         spd_sel = VEC[v].sel;
         run_frames(int'(VEC[v].per), 5);
         tag = $sformatf("R%0d row %0d", VEC[v].req, v);
         chk(int'(spd_mode), int'(VEC[v].mode), tag, "spd_mode");
         chk(int'(osr_code), int'(VEC[v].osr), tag, "osr_code");
         chk(int'(ratio_err), int'(VEC[v].err), tag, "ratio_err");
         chk(int'(locked), int'(!VEC[v].err), tag, "locked");
         chk(int'(mode_valid), 1, tag, "mode_valid");
      end

      // R8: a lone frame of another legal ratio does not switch the mode
      spd_sel = 2'b00;
      run_frames(256, 5);
      chk(int'(osr_code), 0, "R8", "settled osr_code");
      run_frames(384, 1);
      frame_clk = 1'b1;
      repeat (20) @(negedge clk);
      chk(int'(osr_code), 0, "R8", "osr_code after one odd frame");
      chk(int'(locked), 0, "R8", "locked after one odd frame");
      chk(int'(ratio_err), 0, "R8", "ratio_err after one odd frame");
      repeat (128 - 20) @(negedge clk);
      frame_clk = 1'b0;
      repeat (128) @(negedge clk);
      frame_clk = 1'b1;
      repeat (20) @(negedge clk);
      chk(int'(osr_code), 0, "R8", "osr_code back on 256");
      chk(int'(locked), 1, "R8", "locked back on 256");
      repeat (128 - 20) @(negedge clk);
      frame_clk = 1'b0;
      repeat (128) @(negedge clk);
      // two agreeing frames of 384 do switch
      run_frames(384, 2);
      frame_clk = 1'b1;
      repeat (20) @(negedge clk);
      chk(int'(osr_code), 1, "R8", "osr_code after two frames");
      chk(int'(locked), 1, "R8", "locked after two frames");
      repeat (192 - 20) @(negedge clk);
      frame_clk = 1'b0;
      repeat (192) @(negedge clk);

      // R1: reset in the middle of operation
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_reset_state();

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule